// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared atomic snooping bus. Each line holds one data word, a tag and a three-state coherence field: Invalid, Shared or Modified. The processor side issues one read or write at a time and holds its request until a one-cycle ready strobe comes back. The bus side raises a request, waits for a grant, and performs its transaction in the grant cycle. Fill data arrives on `bus_rdata_i` in that same cycle.

At the same time the controller watches every transaction that other caches put on the bus. It answers each one combinationally in the cycle it appears, and drives flush data when it owns the line. Writes to Shared lines use an upgrade command that carries no data. A policy input chooses where a Modified line goes after another cache reads it: Shared, or Invalid for data that migrates between caches. A replaced Modified line is written back under its own grant before the fill is requested.

Bus command encoding, on both `bus_cmd_o` and `snp_cmd_i`: 0 none, 1 read-shared, 2 read-exclusive, 3 upgrade, 4 writeback. Addresses split into the low `log2(LINES)` bits as line index and the remaining bits as tag.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: A read whose line is valid (Shared or Modified) and whose tag matches raises `cpu_ready_o` for exactly one cycle. This happens in the cycle after acceptance, with the line data on `cpu_rdata_o` and no bus request.
- R2: A read miss issues a read-shared (1) for the requested address. The word on `bus_rdata_i` in the grant cycle is returned to the processor, and the line becomes Shared.
- R3: A write to a line that is Invalid or has another tag issues a read-exclusive (2), and the line becomes Modified with the written word.
- R4: A write to a Shared line with a matching tag issues an upgrade (3) and leaves the line Modified with the written word.
- R5: A write to a Modified line with a matching tag completes locally, one cycle after acceptance, with no bus request.
- R6: A miss that replaces a Modified line first issues a writeback (4) carrying the old tag's address and data. The fill for the new address is then issued under a separate grant.
- R7: A miss that replaces a Shared line drops it silently and issues only the fill.
- R8: A snooped read-shared that hits a Modified line asserts `snp_flush_o` with the line's data in the same cycle. Afterwards the line is Shared when `mig_inv_i` is 0 and Invalid when it is 1. A hit on a Shared line leaves it Shared with no flush.
- R9: A snooped read-exclusive or upgrade that hits a line invalidates it. If the line was Modified it is flushed in the same cycle; if it was Shared it is not.
- R10: The local copy changes to Modified only in the cycle that the write's bus transaction is granted. While the request waits, snoops still see the old state.
- R11: A pending upgrade whose line is invalidated by a snoop before the grant is reissued as a read-exclusive.
- R12: When a snoop flushes and invalidates the victim line while its writeback is still waiting, the writeback is dropped and the fill is requested directly.
- R13: After reset every line is Invalid, and `cpu_ready_o`, `bus_req_o`, `bus_cmd_o` and `snp_flush_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mig_inv_i | input | 1 | Policy: 1 sends a Modified line to Invalid on a snooped read-shared |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 write, 0 read |
| cpu_addr_i | input | ADDR_W | Processor address |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_rdata_o | output | DATA_W | Read word, valid with ready |
| cpu_ready_o | output | 1 | One-cycle completion strobe |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant; the transaction happens in this cycle |
| bus_cmd_o | output | 3 | Own bus command |
| bus_addr_o | output | ADDR_W | Own bus address |
| bus_wdata_o | output | DATA_W | Writeback data |
| bus_rdata_i | input | DATA_W | Fill data in the grant cycle |
| snp_cmd_i | input | 3 | Command issued by another cache |
| snp_addr_i | input | ADDR_W | Address of the snooped command |
| snp_flush_o | output | 1 | This cache supplies the line |
| snp_data_o | output | DATA_W | Flushed word |

## Verification
The bench keeps a model of every line's state, tag and data and of memory. It sweeps each line index under both policy settings through fills, hits, upgrades, evictions and snoops, and compares every bus transaction and returned word with the model.

Three races get directed sequences:
- A snoop arriving while an upgrade waits must see no flush. A design that updated the line before the grant would flush there.
- A following read-exclusive snoop must turn the pending upgrade into a read-exclusive. A design that kept the stale command would issue an upgrade for a line it no longer holds.
- A snoop that takes the victim during a pending writeback must cancel the writeback. A design that missed this would write stale data to memory over the flushed copy.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPGR = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              fsm_we_i,
  input  logic [IDX_W-1:0]  fsm_idx_i,
  input  line_st_e          fsm_st_i,
  input  logic [TAG_W-1:0]  fsm_tag_i,
  input  logic [DATA_W-1:0] fsm_data_i,
  input  logic              snp_we_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  line_st_e          snp_st_i
);
  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fsm_we_i && fsm_idx_i == IDX_W'(i)) begin
          st_q[i]   <= fsm_st_i;
          tag_q[i]  <= fsm_tag_i;
          data_q[i] <= fsm_data_i;
        end else if (snp_we_i && snp_idx_i == IDX_W'(i)) begin
          st_q[i] <= snp_st_i;
        end
      end
    end
  end

  assign a_st_o   = st_q[a_idx_i];
  assign a_tag_o  = tag_q[a_idx_i];
  assign a_data_o = data_q[a_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_data_o = data_q[b_idx_i];

  // own and snoop updates never target the same line in one cycle
  assert_single_writer_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fsm_we_i && snp_we_i && fsm_idx_i == snp_idx_i));

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    // a line becomes valid only through the controller's own write port
    assert_valid_via_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == ST_I && !(fsm_we_i && fsm_idx_i == IDX_W'(g))) |=> st_q[g] == ST_I);
  end
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              mig_inv_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o,
  output logic              we_o,
  output line_st_e          st_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] data_o
);
  logic tag_hit;

  assign idx_o   = snp_addr_i[IDX_W-1:0];
  assign tag_hit = (line_st_i != ST_I) && (line_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);

  always_comb begin
    hit_o   = 1'b0;
    we_o    = 1'b0;
    st_o    = line_st_i;
    flush_o = 1'b0;
    case (snp_cmd_i)
      CMD_RD: begin
        hit_o = tag_hit;
        if (tag_hit && line_st_i == ST_M) begin
          we_o    = 1'b1;
          flush_o = 1'b1;
          st_o    = mig_inv_i ? ST_I : ST_S;
        end
      end
      CMD_RDX, CMD_UPGR: begin
        hit_o = tag_hit;
        if (tag_hit) begin
          we_o    = 1'b1;
          st_o    = ST_I;
          flush_o = (line_st_i == ST_M);
        end
      end
      default: ;
    endcase
  end

  assign data_o = flush_o ? line_data_i : '0;
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_hit_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  output logic [IDX_W-1:0]  a_idx_o,
  input  line_st_e          a_st_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic              wr_en_o,
  output line_st_e          wr_st_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o
);
  typedef enum logic [1:0] {F_IDLE, F_WB, F_ACQ, F_RESP} fsm_e;

  fsm_e              state_q, state_d;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q, cur_addr;
  logic [DATA_W-1:0] req_wdata_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ready_q, ready_d;
  logic              latch;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              tag_hit, snoop_block;
  bus_cmd_e          cmd;

  assign cur_addr    = (state_q == F_IDLE) ? cpu_addr_i : req_addr_q;
  assign cur_idx     = cur_addr[IDX_W-1:0];
  assign cur_tag     = cur_addr[ADDR_W-1:IDX_W];
  assign a_idx_o     = cur_idx;
  assign tag_hit     = (a_st_i != ST_I) && (a_tag_i == cur_tag);
  // hold off acceptance while a snoop touches the same line this cycle
  assign snoop_block = snp_hit_i && (snp_idx_i == cur_idx);

  always_comb begin
    state_d     = state_q;
    latch       = 1'b0;
    bus_req_o   = 1'b0;
    cmd         = CMD_NONE;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    wr_en_o     = 1'b0;
    wr_st_o     = a_st_i;
    wr_tag_o    = a_tag_i;
    wr_data_o   = a_data_i;
    ready_d     = 1'b0;
    rdata_d     = rdata_q;
    case (state_q)
      F_IDLE: begin
        if (cpu_req_i && !snoop_block) begin
          latch = 1'b1;
          if (!cpu_we_i && tag_hit) begin
            ready_d = 1'b1;
            rdata_d = a_data_i;
            state_d = F_RESP;
          end else if (cpu_we_i && tag_hit && a_st_i == ST_M) begin
            wr_en_o   = 1'b1;
            wr_data_o = cpu_wdata_i;
            ready_d   = 1'b1;
            state_d   = F_RESP;
          end else if (!tag_hit && a_st_i == ST_M) begin
            state_d = F_WB;
          end else begin
            state_d = F_ACQ;
          end
        end
      end
      F_WB: begin
        if (a_st_i == ST_M) begin
          bus_req_o   = 1'b1;
          cmd         = CMD_WB;
          bus_addr_o  = {a_tag_i, cur_idx};
          bus_wdata_o = a_data_i;
          if (bus_gnt_i) begin
            wr_en_o = 1'b1;
            wr_st_o = ST_I;
            state_d = F_ACQ;
          end
        end else begin
          // victim already taken by a snoop: nothing to write back
          state_d = F_ACQ;
        end
      end
      F_ACQ: begin
        bus_req_o  = 1'b1;
        bus_addr_o = cur_addr;
        if (req_we_q) cmd = (tag_hit && a_st_i == ST_S) ? CMD_UPGR : CMD_RDX;
        else          cmd = CMD_RD;
        if (bus_gnt_i) begin
          wr_en_o   = 1'b1;
          wr_tag_o  = cur_tag;
          wr_st_o   = req_we_q ? ST_M : ST_S;
          wr_data_o = req_we_q ? req_wdata_q : bus_rdata_i;
          rdata_d   = req_we_q ? rdata_q : bus_rdata_i;
          ready_d   = 1'b1;
          state_d   = F_RESP;
        end
      end
      default: state_d = F_IDLE;
    endcase
  end

  assign bus_cmd_o = cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= F_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      rdata_q     <= '0;
      ready_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
      rdata_q <= rdata_d;
      if (latch) begin
        req_we_q    <= cpu_we_i;
        req_addr_q  <= cpu_addr_i;
        req_wdata_q <= cpu_wdata_i;
      end
    end
  end

  assign cpu_ready_o = ready_q;
  assign cpu_rdata_o = rdata_q;

  assert_ready_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o);

  assert_m_only_on_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_st_o == ST_M && a_st_i != ST_M) |-> (bus_req_o && bus_gnt_i));

  assert_wb_then_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == CMD_WB) |=> (bus_req_o && bus_cmd_o != CMD_WB));
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mig_inv_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx;
  line_st_e          a_st, b_st, wr_st, snp_st;
  logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
  logic [DATA_W-1:0] a_data, b_data, wr_data;
  logic              wr_en, snp_we, snp_hit;

  msi_line_store #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_idx_i    (a_idx),
    .a_st_o     (a_st),
    .a_tag_o    (a_tag),
    .a_data_o   (a_data),
    .b_idx_i    (b_idx),
    .b_st_o     (b_st),
    .b_tag_o    (b_tag),
    .b_data_o   (b_data),
    .fsm_we_i   (wr_en),
    .fsm_idx_i  (a_idx),
    .fsm_st_i   (wr_st),
    .fsm_tag_i  (wr_tag),
    .fsm_data_i (wr_data),
    .snp_we_i   (snp_we),
    .snp_idx_i  (b_idx),
    .snp_st_i   (snp_st)
  );

  msi_snoop_unit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) i_snoop (
    .snp_cmd_i   (snp_cmd_i),
    .snp_addr_i  (snp_addr_i),
    .mig_inv_i   (mig_inv_i),
    .line_st_i   (b_st),
    .line_tag_i  (b_tag),
    .line_data_i (b_data),
    .idx_o       (b_idx),
    .hit_o       (snp_hit),
    .we_o        (snp_we),
    .st_o        (snp_st),
    .flush_o     (snp_flush_o),
    .data_o      (snp_data_o)
  );

  msi_req_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_rdata_o (cpu_rdata_o),
    .cpu_ready_o (cpu_ready_o),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_cmd_o   (bus_cmd_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .snp_hit_i   (snp_hit),
    .snp_idx_i   (b_idx),
    .a_idx_o     (a_idx),
    .a_st_i      (a_st),
    .a_tag_i     (a_tag),
    .a_data_i    (a_data),
    .wr_en_o     (wr_en),
    .wr_st_o     (wr_st),
    .wr_tag_o    (wr_tag),
    .wr_data_o   (wr_data)
  );
endmodule

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;
  localparam int C_NONE = 0, C_RD = 1, C_RDX = 2, C_UPGR = 3, C_WB = 4;
  localparam int S_I = 0, S_S = 1, S_M = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mig_inv = 1'b0;
  logic       cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_ready;
  logic       bus_req, bus_gnt = 1'b0;
  logic [2:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic [2:0] snp_cmd = '0;
  logic [7:0] snp_addr = '0;
  logic       snp_flush;
  logic [7:0] snp_data;

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  int         m_st   [4];
  logic [5:0] m_tag  [4];
  logic [7:0] m_data [4];
  logic [7:0] mem    [256];

  always #10 clk = ~clk;

  msi_snoop_ctrl i_msi_snoop_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mig_inv_i(mig_inv),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_flush_o(snp_flush), .snp_data_o(snp_data)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input logic [7:0] addr, input logic [7:0] wd);
    int idx = int'(addr[1:0]);
    bit hit = (m_st[idx] != S_I) && (m_tag[idx] == addr[7:2]);
    int e_cmd [2];
    logic [7:0] e_addr [2];
    logic [7:0] e_data [2];
    int n_exp = 0, got = 0, cyc = 0;
    bit done = 0;
    string rq;
    logic [7:0] exp_rd;
    if (!we && hit) rq = "R1";
    else if (we && hit && m_st[idx] == S_M) rq = "R5";
    else begin
      if (!hit && m_st[idx] == S_M) begin
        e_cmd[0] = C_WB; e_addr[0] = {m_tag[idx], 2'(idx)}; e_data[0] = m_data[idx];
        n_exp = 1;
      end
      e_cmd[n_exp]  = !we ? C_RD : ((hit && m_st[idx] == S_S) ? C_UPGR : C_RDX);
      e_addr[n_exp] = addr; e_data[n_exp] = '0;
      n_exp++;
      if (n_exp == 2) rq = "R6";
      else if (!hit && m_st[idx] == S_S) rq = "R7";
      else if (e_cmd[0] == C_RD) rq = "R2";
      else if (e_cmd[0] == C_RDX) rq = "R3";
      else rq = "R4";
    end
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    while (!done) begin
      @(negedge clk);
      bus_gnt = 1'b0;
      cyc++;
      if (cpu_ready) done = 1;
      else if (cyc > 60) begin
        check(0, {rq, " timeout"}, cyc, 0);
        done = 1;
      end else if (bus_req) begin
        if (got < n_exp) begin
          check(int'(bus_cmd) == e_cmd[got], {rq, " cmd"}, int'(bus_cmd), e_cmd[got]);
          check(bus_addr == e_addr[got], {rq, " addr"}, int'(bus_addr), int'(e_addr[got]));
          if (e_cmd[got] == C_WB)
            check(bus_wdata == e_data[got], {rq, " wb data"}, int'(bus_wdata), int'(e_data[got]));
        end else check(0, {rq, " extra txn"}, int'(bus_cmd), C_NONE);
        if (int'(bus_cmd) == C_WB) mem[bus_addr] = bus_wdata;
        bus_rdata = mem[bus_addr];
        bus_gnt = 1'b1;
        got++;
      end
    end
    check(got == n_exp, {rq, " txn count"}, got, n_exp);
    if (n_exp == 0) check(cyc == 1, {rq, " latency"}, cyc, 1);
    exp_rd = hit ? m_data[idx] : mem[addr];
    if (!we) check(cpu_rdata == exp_rd, {rq, " rdata"}, int'(cpu_rdata), int'(exp_rd));
    cpu_req = 1'b0;
    m_data[idx] = we ? wd : exp_rd;
    m_st[idx]   = we ? S_M : (hit ? m_st[idx] : S_S);
    m_tag[idx]  = addr[7:2];
  endtask

  task automatic snoop(input int cmd, input logic [7:0] addr, input string rq);
    int idx = int'(addr[1:0]);
    bit hit = (m_st[idx] != S_I) && (m_tag[idx] == addr[7:2]);
    bit ef = 0;
    logic [7:0] ed = '0;
    if (hit && m_st[idx] == S_M && cmd != C_WB) begin ef = 1; ed = m_data[idx]; end
    @(negedge clk);
    snp_cmd = 3'(cmd); snp_addr = addr;
    #2;
    check(snp_flush == ef, {rq, " flush"}, int'(snp_flush), int'(ef));
    check(snp_data == ed, {rq, " flush data"}, int'(snp_data), int'(ed));
    @(negedge clk);
    snp_cmd = '0;
    if (ef) mem[addr] = ed;
    if (hit) begin
      if (cmd == C_RDX || cmd == C_UPGR) m_st[idx] = S_I;
      else if (cmd == C_RD && m_st[idx] == S_M) m_st[idx] = mig_inv ? S_I : S_S;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 4; i++) begin m_st[i] = S_I; m_tag[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    check(cpu_ready == 0 && bus_req == 0 && bus_cmd == 0 && snp_flush == 0,
          "R13 outputs in reset", int'({cpu_ready, bus_req, bus_cmd, snp_flush}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready == 0 && bus_req == 0 && bus_cmd == 0, "R13 outputs after reset",
          int'({cpu_ready, bus_req, bus_cmd}), 0);
    for (int i = 0; i < 4; i++) snoop(C_RDX, 8'(i), "R13 all lines invalid");

    for (int mig = 0; mig < 2; mig++) begin
      mig_inv = 1'(mig);
      for (int idx = 0; idx < 4; idx++) begin
        logic [7:0] a = {6'(idx + 1 + mig * 8), 2'(idx)};
        logic [7:0] b = {6'(idx + 17 + mig * 8), 2'(idx)};
        cpu_op(0, a, '0);
        cpu_op(0, a, '0);
        cpu_op(1, a, 8'(8'h30 + idx));
        cpu_op(1, a, 8'(8'h40 + idx));
        snoop(C_RD, a, "R8");
        cpu_op(1, a, 8'(8'h50 + idx));
        cpu_op(0, b, '0);
        snoop(C_RD, b, "R8 shared no flush");
        cpu_op(1, a, 8'(8'h60 + idx));
        snoop(C_RDX, a, "R9");
        cpu_op(1, b, 8'(8'h70 + idx));
        cpu_op(0, a, '0);
        snoop(C_UPGR, a, "R9 shared");
        cpu_op(0, a, '0);
      end
    end
    mig_inv = 1'b0;

    // pending upgrade observed by snoops, then converted
    cpu_op(0, 8'h50, '0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h50; cpu_wdata = 8'hA5;
    @(negedge clk);
    check(bus_req && int'(bus_cmd) == C_UPGR, "R4 pending upgrade", int'(bus_cmd), C_UPGR);
    snoop(C_RD, 8'h50, "R10");
    snoop(C_RDX, 8'h50, "R11");
    check(bus_req && int'(bus_cmd) == C_RDX, "R11 converted cmd", int'(bus_cmd), C_RDX);
    bus_rdata = mem[8'h50]; bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check(cpu_ready == 1, "R11 ready", int'(cpu_ready), 1);
    cpu_req = 1'b0;
    m_st[0] = S_M; m_tag[0] = 6'h14; m_data[0] = 8'hA5;
    snoop(C_RD, 8'h50, "R10 after grant");

    // victim flushed by a snoop while its writeback waits
    cpu_op(1, 8'h61, 8'h3C);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h65;
    @(negedge clk);
    check(bus_req && int'(bus_cmd) == C_WB && bus_addr == 8'h61, "R6 pending wb",
          int'(bus_cmd), C_WB);
    snoop(C_RDX, 8'h61, "R12");
    @(negedge clk);
    check(bus_req && int'(bus_cmd) == C_RD && bus_addr == 8'h65, "R12 wb dropped",
          int'(bus_cmd), C_RD);
    bus_rdata = mem[8'h65]; bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check(cpu_ready == 1 && cpu_rdata == mem[8'h65], "R12 fill data",
          int'(cpu_rdata), int'(mem[8'h65]));
    cpu_req = 1'b0;
    m_st[1] = S_S; m_tag[1] = 6'h19; m_data[1] = mem[8'h65];
    cpu_op(0, 8'h65, '0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule